// File: doc/BRIEF.md
# Byte-wide synchronous serial port controller

This block moves one byte at a time over a three-wire synchronous serial link: a serial clock, a data-out line and a data-in line. The host sees an 8-bit shift register that it can load and read in parallel, a mode-write strobe that also resets the port, and a start strobe. A start arms the port, but shifting waits for the first falling edge of the serial clock. Bits leave least significant first on falling edges and enter on rising edges, so after eight clocks the register holds the received byte. A one-cycle completion pulse marks the end of every byte, whether it finishes normally or is cut short.

The serial clock comes from one of two sources. In external mode it is an input, brought into the system clock domain by a synchronizer and an edge detector. In internal mode the block drives the clock itself, dividing the system clock by a fixed ratio. In internal mode a free-running setting makes the block keep emitting the clock without shifting any data.

The controller has four named states: IDLE (encoding 00), WAIT (01, armed and waiting for a falling edge), XFER (10, a byte in flight) and CONT (11, free-running clock). The transitions are:

- arm: IDLE to WAIT on start.
- begin: WAIT to XFER on a falling edge.
- freerun: WAIT to CONT on a falling edge when internal and free-running modes are both set.
- finish: XFER to WAIT on the eighth rising edge.
- abort: XFER to WAIT on start.
- reset: any state to IDLE on a mode write.

Top module: `ser8_ctrl`

## Requirements
- R1: After reset, `port_state` is IDLE (00), `sck_out` and `sdo` are 1, `sck_oe` and `done` are 0, and `dat_out` is 0x00.
- R2: In IDLE, serial clock edges change neither the state nor the register. Only start leaves IDLE, and it moves the port to WAIT (01).
- R3: In WAIT, the first falling serial clock edge moves the port to XFER (10) and drives `sdo` with bit 0 of the register. The 3-bit bit counter starts counting from zero.
- R4: Each falling edge in a transfer drives `sdo` with the next bit, least significant first. Each rising edge shifts `sdi` into bit 7 while the register moves right. After eight clocks, `dat_out` equals the received byte with the first received bit in bit 0.
- R5: The port stays in XFER through the first seven clocks. On the eighth rising edge it returns to WAIT with the counter at zero and pulses `done` for one cycle. In external mode the next falling edge starts another byte.
- R6: A start during XFER ends the byte early. It pulses `done`, returns the port to WAIT and clears the counter, so the next byte again takes eight full clocks.
- R7: A mode write moves any state to IDLE in the next cycle and captures `mode_int_in` and `mode_cont_in`. It pulses `done` only when the port was in XFER.
- R8: In internal mode, `sck_oe` is 1 and the clock idles high. The first falling edge comes DIV/2 system cycles after the port enters WAIT, and the clock period is DIV cycles (8 by default). After a finished byte, the clock stays high until the next start. In external mode, `sck_oe` is 0.
- R9: With internal and free-running modes both set, the first falling edge in WAIT moves the port to CONT (11). In CONT the clock toggles every DIV/2 cycles, no data shifts, `done` stays low and start is ignored. Only a mode write leaves CONT.
- R10: `dat_wr` loads `dat_in` into the register in IDLE, WAIT and CONT. It has no effect during XFER.
- R11: In external mode, a level on `sck_in` that is held for at least four system cycles is acted on within three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode-write strobe; also returns the port to IDLE |
| mode_int_in | input | 1 | Mode bit captured on mode write: 1 = internal clock |
| mode_cont_in | input | 1 | Mode bit captured on mode write: 1 = free-running clock |
| start | input | 1 | Start command strobe |
| dat_wr | input | 1 | Parallel load strobe for the shift register |
| dat_in | input | 8 | Parallel load data |
| dat_out | output | 8 | Shift register contents |
| done | output | 1 | One-cycle completion pulse |
| port_state | output | 2 | Current state encoding |
| sck_in | input | 1 | Serial clock input (external mode) |
| sck_out | output | 1 | Serial clock output (internal mode) |
| sck_oe | output | 1 | Serial clock output enable |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: an 8-bit register, a divide-by-8 clock and a two-stage synchronizer. At these sizes, all 256 transmit bytes can be swept through external-mode transfers, each paired with a received byte that the bench computes arithmetically. The short internal clock period makes the exact cycle of the first falling edge and the free-running toggle count practical to check. It also keeps the abort and mode-write cases, taken at chosen bit positions, within a few hundred cycles.

// File: rtl/ser8_pkg.sv
package ser8_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_XFER = 2'b10,
        ST_CONT = 2'b11
    } port_st_t;
endpackage

// File: rtl/ser8_clkgen.sv
module ser8_clkgen #(
    parameter int DIV   = 8,
    parameter int SYNC  = 2,
    localparam int HALF = DIV / 2,
    localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_int,
    input  logic gen_run,
    input  logic sck_in,
    output logic gen_sck,
    output logic fall,
    output logic rise
);
    // external path: synchronizer chain plus one history flop
    logic [SYNC:0] chain;
    genvar g;
    generate
        for (g = 0; g <= SYNC; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= sck_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    logic ext_fall, ext_rise;
    assign ext_fall = chain[SYNC] & ~chain[SYNC-1];
    assign ext_rise = ~chain[SYNC] & chain[SYNC-1];

    // internal path: half-period counter and clock level
    logic [HW-1:0] hc;
    logic          sck_q;
    logic          hc_end;
    assign hc_end = gen_run && (hc == HW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hc    <= '0;
            sck_q <= 1'b1;
        end else if (!gen_run) begin
            hc    <= '0;
            sck_q <= 1'b1;
        end else if (hc_end) begin
            hc    <= '0;
            sck_q <= ~sck_q;
        end else begin
            hc    <= hc + 1'b1;
        end
    end

    assign gen_sck = sck_q;
    assign fall    = mode_int ? (hc_end &&  sck_q) : ext_fall;
    assign rise    = mode_int ? (hc_end && !sck_q) : ext_rise;
endmodule

// File: rtl/ser8_fsm.sv
module ser8_fsm
    import ser8_pkg::*;
#(
    parameter int DW  = 8,
    localparam int CW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr,
    input  logic          mode_int_in,
    input  logic          mode_cont_in,
    input  logic          start,
    input  logic          dat_wr,
    input  logic          fall,
    input  logic          rise,
    output port_st_t      st,
    output logic          mode_int,
    output logic          gen_run,
    output logic          shift_out,
    output logic          sample,
    output logic          load,
    output logic          done,
    output logic [CW-1:0] cnt
);
    port_st_t nx;
    logic     mode_cont;
    logic     armed;
    logic     last;
    logic     go_cont;
    logic     done_set;
    logic     finish;

    assign go_cont = mode_int && mode_cont;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nx;
    end

    // next state
    always_comb begin
        nx = st;
        if (mode_wr) begin
            nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: if (start) nx = ST_WAIT;
                ST_WAIT: if (fall)  nx = go_cont ? ST_CONT : ST_XFER;
                ST_XFER: if (start || (rise && last)) nx = ST_WAIT;
                ST_CONT: nx = ST_CONT;
            endcase
        end
    end

    // outputs
    always_comb begin
        shift_out = 1'b0;
        sample    = 1'b0;
        finish    = 1'b0;
        done_set  = 1'b0;
        load      = dat_wr && (st != ST_XFER);
        gen_run   = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_WAIT: begin
                gen_run   = armed;
                shift_out = !mode_wr && fall && !go_cont;
            end
            ST_XFER: begin
                gen_run   = 1'b1;
                shift_out = !mode_wr && !start && fall;
                sample    = !mode_wr && !start && rise;
                finish    = sample && last;
                done_set  = mode_wr || start || finish;
            end
            ST_CONT: gen_run = 1'b1;
        endcase
    end

    // mode bits, bit counter, arm flag, completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_int  <= 1'b0;
            mode_cont <= 1'b0;
            armed     <= 1'b0;
            last      <= 1'b0;
            cnt       <= '0;
            done      <= 1'b0;
        end else begin
            done <= done_set;
            if (mode_wr) begin
                mode_int  <= mode_int_in;
                mode_cont <= mode_cont_in;
                armed     <= 1'b0;
                last      <= 1'b0;
                cnt       <= '0;
            end else if (start && (st != ST_CONT)) begin
                armed <= 1'b1;
                last  <= 1'b0;
                cnt   <= '0;
            end else if (shift_out) begin
                cnt  <= cnt + 1'b1;
                last <= (cnt == CW'(DW - 1));
            end else if (finish) begin
                last  <= 1'b0;
                armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ser8_shifter.sv
module ser8_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] dat_in,
    input  logic          shift_out,
    input  logic          sample,
    input  logic          sdi,
    output logic [DW-1:0] sr,
    output logic          sdo
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr  <= '0;
            sdo <= 1'b1;
        end else begin
            if (sample)    sr  <= {sdi, sr[DW-1:1]};
            else if (load) sr  <= dat_in;
            if (shift_out) sdo <= sr[0];
        end
    end
endmodule

// File: rtl/ser8_ctrl.sv
module ser8_ctrl
    import ser8_pkg::*;
#(
    parameter int DW   = 8,
    parameter int DIV  = 8,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr,
    input  logic          mode_int_in,
    input  logic          mode_cont_in,
    input  logic          start,
    input  logic          dat_wr,
    input  logic [DW-1:0] dat_in,
    output logic [DW-1:0] dat_out,
    output logic          done,
    output logic [1:0]    port_state,
    input  logic          sck_in,
    output logic          sck_out,
    output logic          sck_oe,
    output logic          sdo,
    input  logic          sdi
);
    localparam int CW = $clog2(DW);

    port_st_t      st;
    logic          mode_int, gen_run, gen_sck;
    logic          fall, rise;
    logic          do_shift, do_sample, do_load;
    logic [CW-1:0] bit_cnt;

    ser8_clkgen #(.DIV(DIV), .SYNC(SYNC)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_int (mode_int),
        .gen_run  (gen_run),
        .sck_in   (sck_in),
        .gen_sck  (gen_sck),
        .fall     (fall),
        .rise     (rise)
    );

    ser8_fsm #(.DW(DW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr      (mode_wr),
        .mode_int_in  (mode_int_in),
        .mode_cont_in (mode_cont_in),
        .start        (start),
        .dat_wr       (dat_wr),
        .fall         (fall),
        .rise         (rise),
        .st           (st),
        .mode_int     (mode_int),
        .gen_run      (gen_run),
        .shift_out    (do_shift),
        .sample       (do_sample),
        .load         (do_load),
        .done         (done),
        .cnt          (bit_cnt)
    );

    ser8_shifter #(.DW(DW)) u_sr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (do_load),
        .dat_in    (dat_in),
        .shift_out (do_shift),
        .sample    (do_sample),
        .sdi       (sdi),
        .sr        (dat_out),
        .sdo       (sdo)
    );

    assign port_state = st;
    assign sck_oe     = mode_int;
    assign sck_out    = mode_int ? gen_sck : 1'b1;
endmodule

// File: rtl/ser8_ctrl_chk.sv
module ser8_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_wr,
    input logic       start,
    input logic       dat_wr,
    input logic       done,
    input logic       sck_out,
    input logic [7:0] dat_out,
    input logic [1:0] st,
    input logic       cnt_zero,
    input logic       sample
);
    p_mode_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (st == 2'b00));

    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'b00 && start && !mode_wr) |=> (st == 2'b01));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'b00 && !start && !mode_wr) |=> (st == 2'b00));

    p_done_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(st) == 2'b10 && st != 2'b10));

    p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'b10 && start && !mode_wr) |=> (done && st == 2'b01));

    p_wait_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'b01) |-> cnt_zero);

    p_cont_stay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'b11 && !mode_wr) |=> (st == 2'b11 && !done));

    p_idle_sck_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'b00 && $past(st) == 2'b00) |-> sck_out);

    p_xfer_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'b10 && dat_wr && !sample) |=> $stable(dat_out));
endmodule

bind ser8_ctrl ser8_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_wr  (mode_wr),
    .start    (start),
    .dat_wr   (dat_wr),
    .done     (done),
    .sck_out  (sck_out),
    .dat_out  (dat_out),
    .st       (port_state),
    .cnt_zero (bit_cnt == '0),
    .sample   (do_sample)
);

// File: tb/sim_ser8_ctrl.sv
`timescale 1ns/1ps
module sim_ser8_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0, mode_int_in = 1'b0, mode_cont_in = 1'b0;
    logic       start = 1'b0, dat_wr = 1'b0;
    logic [7:0] dat_in = 8'h00;
    logic [7:0] dat_out;
    logic       done;
    logic [1:0] port_state;
    logic       sck_in = 1'b1;
    logic       sck_out, sck_oe, sdo;
    logic       sdi = 1'b0;

    int total = 0;
    int bad = 0;
    int ndone = 0;
    bit finished = 1'b0;

    // slave model for internal-clock transfers
    bit         slv_en = 1'b0;
    logic [7:0] slv_tx = 8'h00;
    logic [7:0] slv_rx = 8'h00;
    int         slv_i = 0;
    logic       sck_seen = 1'b1;

    always #2 clk = ~clk;

    ser8_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_int_in(mode_int_in),
        .mode_cont_in(mode_cont_in), .start(start), .dat_wr(dat_wr),
        .dat_in(dat_in), .dat_out(dat_out), .done(done), .port_state(port_state),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .sdo(sdo), .sdi(sdi)
    );

    always @(posedge clk) if (rst_n && done) ndone++;

    always @(negedge clk) begin
        if (slv_en && sck_seen && !sck_out && slv_i < 8) begin
            slv_rx[slv_i] = sdo;
            sdi = slv_tx[slv_i];
            slv_i++;
        end
        sck_seen = sck_out;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_mode(input logic mi, input logic mc);
        mode_int_in = mi; mode_cont_in = mc; mode_wr = 1'b1;
        tick(1);
        mode_wr = 1'b0;
    endtask

    task automatic do_start();
        start = 1'b1;
        tick(1);
        start = 1'b0;
    endtask

    task automatic do_load(input logic [7:0] v);
        dat_in = v; dat_wr = 1'b1;
        tick(1);
        dat_wr = 1'b0;
    endtask

    task automatic ext_fall();
        sck_in = 1'b0;
        tick(4);
    endtask

    task automatic ext_rise(input logic b);
        sdi = b;
        sck_in = 1'b1;
        tick(4);
    endtask

    // one full external-mode byte starting from WAIT
    task automatic ext_byte(input logic [7:0] tx, input logic [7:0] rx, input bit verbose);
        int d0;
        d0 = ndone;
        for (int i = 0; i < 8; i++) begin
            ext_fall();
            if (verbose || sdo != tx[i]) chk("R4 sdo bit", sdo, tx[i]);
            if (i == 0) chk("R3 enter XFER", port_state, 2);
            ext_rise(rx[i]);
            if (i < 7 && (verbose || port_state != 2)) chk("R5 still XFER", port_state, 2);
        end
        chk("R5 back to WAIT", port_state, 1);
        chk("R4 received byte", dat_out, rx);
        chk("R5 one done pulse", ndone, d0 + 1);
    endtask

    initial begin
        int d0;
        int tog;
        logic last_sck;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 state", port_state, 0);
        chk("R1 sck_out", sck_out, 1);
        chk("R1 sdo", sdo, 1);
        chk("R1 sck_oe", sck_oe, 0);
        chk("R1 done", done, 0);
        chk("R1 dat_out", dat_out, 0);

        // R2: idle ignores the clock
        do_mode(1'b0, 1'b0);
        chk("R8 ext oe", sck_oe, 0);
        do_load(8'hC3);
        for (int i = 0; i < 8; i++) begin ext_fall(); ext_rise(1'b0); end
        chk("R2 idle state", port_state, 0);
        chk("R2 idle data", dat_out, 8'hC3);
        chk("R2 idle sdo", sdo, 1);
        chk("R2 idle no done", ndone, 0);
        do_start();
        chk("R2 start arms", port_state, 1);

        // R4/R5/R11: sweep all transmit bytes in external mode
        for (int v = 0; v < 256; v++) begin
            do_load(8'(v));
            ext_byte(8'(v), 8'((v * 37 + 11) & 255), v < 2);
        end

        // R10: load ignored mid-byte
        do_load(8'h6B);
        d0 = ndone;
        for (int i = 0; i < 8; i++) begin
            ext_fall();
            chk("R10 sdo after blocked load", sdo, (8'h6B >> i) & 1);
            if (i == 2) do_load(8'h00);
            ext_rise(1'b1);
        end
        chk("R10 byte intact", dat_out, 8'hFF);

        // R6: abort with start after three bits
        do_load(8'h3C);
        d0 = ndone;
        for (int i = 0; i < 3; i++) begin ext_fall(); ext_rise(1'b0); end
        do_start();
        chk("R6 abort to WAIT", port_state, 1);
        tick(1);
        chk("R6 abort done", ndone, d0 + 1);
        do_load(8'h96);
        ext_byte(8'h96, 8'h5A, 1'b1);

        // R7: mode write during XFER and in WAIT
        do_load(8'h11);
        d0 = ndone;
        ext_fall(); ext_rise(1'b1); ext_fall();
        do_mode(1'b0, 1'b0);
        chk("R7 xfer to IDLE", port_state, 0);
        tick(1);
        chk("R7 xfer done", ndone, d0 + 1);
        ext_rise(1'b0);
        do_start();
        d0 = ndone;
        do_mode(1'b0, 1'b0);
        tick(1);
        chk("R7 wait to IDLE", port_state, 0);
        chk("R7 wait no done", ndone, d0);

        // R8: internal clock timing
        do_mode(1'b1, 1'b0);
        chk("R8 int oe", sck_oe, 1);
        chk("R8 idle high", sck_out, 1);
        do_load(8'hA7);
        slv_tx = 8'h4E; slv_i = 0; slv_en = 1'b1;
        do_start();
        tick(3);
        chk("R8 before first fall", sck_out, 1);
        tick(1);
        chk("R8 first fall", sck_out, 0);
        chk("R3 int XFER", port_state, 2);
        tick(3);
        chk("R8 low half", sck_out, 0);
        tick(1);
        chk("R8 rise", sck_out, 1);
        tick(72);
        chk("R4 int tx", slv_rx, 8'hA7);
        chk("R4 int rx", dat_out, 8'h4E);
        chk("R5 int WAIT", port_state, 1);
        chk("R8 clock parked", sck_out, 1);
        slv_en = 1'b0;

        for (int v = 0; v < 16; v++) begin
            do_load(8'(v * 17 + 3));
            slv_tx = 8'(255 - v * 9); slv_i = 0; slv_en = 1'b1;
            d0 = ndone;
            do_start();
            tick(80);
            chk("R4 int sweep tx", slv_rx, (v * 17 + 3) & 255);
            chk("R4 int sweep rx", dat_out, (255 - v * 9) & 255);
            chk("R5 int sweep done", ndone, d0 + 1);
            slv_en = 1'b0;
        end

        // R9: free-running clock
        do_mode(1'b1, 1'b1);
        do_load(8'h5D);
        d0 = ndone;
        do_start();
        tick(5);
        chk("R9 enter CONT", port_state, 3);
        tog = 0; last_sck = sck_out;
        for (int i = 0; i < 64; i++) begin
            tick(1);
            if (sck_out != last_sck) tog++;
            last_sck = sck_out;
        end
        chk("R9 toggles", tog, 16);
        chk("R9 no shift", dat_out, 8'h5D);
        do_start();
        tick(2);
        chk("R9 start ignored", port_state, 3);
        chk("R9 no done", ndone, d0);
        do_load(8'hE1);
        chk("R10 load in CONT", dat_out, 8'hE1);
        do_mode(1'b1, 1'b1);
        tick(1);
        chk("R9 leave CONT", port_state, 0);
        tog = 0;
        for (int i = 0; i < 16; i++) begin tick(1); if (!sck_out) tog++; end
        chk("R8 idle clock high", tog, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule